// File: doc/BRIEF.md
# Pushbutton Power Sequencer

This block turns system power on and off from a single momentary pushbutton. A press held long enough raises a power-enable output. The processor that then boots must confirm that it is alive by driving its kill line high before a fixed blanking window ends. Later, a held press or a sustained undervoltage condition pulls an interrupt line low, so that the processor can shut down in an orderly way. The processor finishes that shutdown by pulling its kill line low. If the press or the undervoltage lasts past a minimum time plus a programmable extra delay, the block drops enable and the interrupt together, without waiting for the processor.

All inputs arrive already synchronised to the clock. Timing is counted in pulses of a one-millisecond tick input. A build parameter chooses whether enable is active high or active low. Both outputs come from flip-flops.

Top module: `pbpwr_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, enable is deasserted and `int_n` is 1.
- R2: Enable is asserted only after `pb_n` has stayed 0 for 32 consecutive ticks while off, with `uv_n` at 1 throughout. The output changes two clocks after the tick that completes the count. A shorter press leaves enable deasserted.
- R3: For 512 ticks after enable rises, `kill_n` is ignored. At the end of that window, enable stays on if `kill_n` is 1 and is released if `kill_n` is 0.
- R4: After the window, `kill_n` at 0 releases enable two clocks later. This also applies while the interrupt is low.
- R5: While on, `pb_n` at 0 or `uv_n` at 0, held for 32 ticks, drives `int_n` to 0. A shorter hold has no effect.
- R6: `int_n` stays 0 for at least 32 ticks and for as long as `pb_n` stays 0. It then returns to 1 while enable stays on.
- R7: If `pb_n` or `uv_n` stays 0 for 64 plus `extra_ms` ticks, enable and the interrupt are both released in the same cycle.
- R8: While `uv_n` is 0, a press does not turn the block on.
- R9: After any power-off, a press held across the power-off does not restart the block. `pb_n` must first return to 1.
- R10: When `EN_ACTIVE_HIGH` is 1, `pwr_en` = 1 means on. When it is 0, `pwr_en` = 0 means on.
- R11: `int_n` is 0 only while enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| pb_n | input | 1 | Pushbutton, 0 = pressed |
| kill_n | input | 1 | Processor kill request, 0 = kill |
| uv_n | input | 1 | Undervoltage flag, 0 = supply low |
| extra_ms | input | XW | Extra power-down delay in milliseconds |
| pwr_en | output | 1 | Power enable, polarity set by `EN_ACTIVE_HIGH` |
| int_n | output | 1 | Power-down interrupt, 0 = request |

## Verification
The bench drives the tick in every cycle, so one millisecond equals one clock. That makes every due time an exact clock count measured from the cycle in which a stimulus is applied:
- Enable appears 34 clocks after a turn-on press, counting the 32-tick count, the state register and the output register.
- The blanking decision lands 546 clocks after the press.
- The interrupt falls 33 clocks after a hold begins.
- A forced release lands 65 plus `extra_ms` clocks after the hold begins.

Each expected value is queued against its absolute cycle number, including the cycle just before a change. The monitor compares the outputs at the falling edge of that exact cycle, so a result that arrives one cycle early or late is reported.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_REARM = 3'd1,
      ST_DEB   = 3'd2,
      ST_BLANK = 3'd3,
      ST_RUN   = 3'd4,
      ST_INTR  = 3'd5
   } pbs_state_e;
endpackage

// File: rtl/pbs_msctr.sv
module pbs_msctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (tick && (cnt != '1))  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
   import pbs_pkg::*;
#(
   parameter int DEB_MS     = 32,
   parameter int BLANK_MS   = 512,
   parameter int INT_MIN_MS = 32,
   parameter int PD_MIN_MS  = 64,
   parameter int XW         = 16,
   parameter int PW         = 10,
   parameter int HW         = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          pb_n,
   input  logic          kill_n,
   input  logic          uv_n,
   input  logic [XW-1:0] extra_ms,
   input  logic [PW-1:0] ph_cnt,
   input  logic [HW-1:0] hold_cnt,
   output logic          ph_clr,
   output logic          hold_clr,
   output logic          en_req,
   output logic          int_req
);
   pbs_state_e    state_q, state_d;
   logic          hold_act, in_on, force_off, deb_hit, int_done;
   logic [HW-1:0] lim_m1;

   assign hold_act = !pb_n || !uv_n;
   assign in_on    = (state_q == ST_RUN) || (state_q == ST_INTR);
   assign hold_clr = !(in_on && hold_act);
   assign lim_m1   = HW'(PD_MIN_MS) + {{(HW-XW){1'b0}}, extra_ms} - HW'(1);
   assign force_off = hold_act && tick && (hold_cnt >= lim_m1);
   assign deb_hit   = hold_act && tick && (hold_cnt == HW'(DEB_MS - 1));
   assign int_done  = (ph_cnt >= PW'(INT_MIN_MS)) ||
                      (tick && (ph_cnt == PW'(INT_MIN_MS - 1)));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF:   if (!pb_n && uv_n) state_d = ST_DEB;
         ST_REARM: if (pb_n) state_d = ST_OFF;
         ST_DEB: begin
            if (pb_n || !uv_n)
               state_d = ST_OFF;
            else if (tick && (ph_cnt == PW'(DEB_MS - 1)))
               state_d = ST_BLANK;
         end
         ST_BLANK: begin
            if (tick && (ph_cnt == PW'(BLANK_MS - 1)))
               state_d = kill_n ? ST_RUN : ST_REARM;
         end
         ST_RUN: begin
            if (!kill_n || force_off) state_d = ST_REARM;
            else if (deb_hit)         state_d = ST_INTR;
         end
         ST_INTR: begin
            if (!kill_n || force_off) state_d = ST_REARM;
            else if (pb_n && int_done) state_d = ST_RUN;
         end
         default: state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end

   assign ph_clr  = (state_d != state_q);
   assign en_req  = (state_q == ST_BLANK) || in_on;
   assign int_req = (state_q == ST_INTR);
endmodule

// File: rtl/pbs_outstage.sv
module pbs_outstage #(
   parameter bit EN_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   input  logic int_req,
   output logic pwr_en,
   output logic int_n
);
   generate
      if (EN_ACTIVE_HIGH) begin : g_en_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwr_en <= 1'b0;
            else        pwr_en <= en_req;
         end
      end else begin : g_en_lo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwr_en <= 1'b1;
            else        pwr_en <= !en_req;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_n <= 1'b1;
      else        int_n <= !int_req;
   end
endmodule

// File: rtl/pbpwr_seq.sv
module pbpwr_seq #(
   parameter bit EN_ACTIVE_HIGH = 1'b1,
   parameter int DEB_MS         = 32,
   parameter int BLANK_MS       = 512,
   parameter int INT_MIN_MS     = 32,
   parameter int PD_MIN_MS      = 64,
   parameter int XW             = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_1ms,
   input  logic          pb_n,
   input  logic          kill_n,
   input  logic          uv_n,
   input  logic [XW-1:0] extra_ms,
   output logic          pwr_en,
   output logic          int_n
);
   localparam int PH_A   = (BLANK_MS > DEB_MS) ? BLANK_MS : DEB_MS;
   localparam int PH_MAX = (PH_A > INT_MIN_MS) ? PH_A : INT_MIN_MS;
   localparam int PW     = $clog2(PH_MAX + 1);
   localparam int HW     = $clog2(PD_MIN_MS + (2 ** XW)) + 1;

   if (DEB_MS < 2) begin : g_bad_deb
      $error("DEB_MS must be at least 2");
   end
   if (PD_MIN_MS <= DEB_MS) begin : g_bad_pd
      $error("PD_MIN_MS must exceed DEB_MS");
   end
   if (INT_MIN_MS < 1 || BLANK_MS < 1) begin : g_bad_win
      $error("window lengths must be positive");
   end
   if (XW < 1 || XW > 24) begin : g_bad_xw
      $error("XW out of range");
   end

   logic          ph_clr, hold_clr, en_req, int_req;
   logic [PW-1:0] ph_cnt;
   logic [HW-1:0] hold_cnt;

   pbs_msctr #(.W(PW)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(ph_clr), .tick(tick_1ms), .cnt(ph_cnt)
   );

   pbs_msctr #(.W(HW)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(hold_clr), .tick(tick_1ms), .cnt(hold_cnt)
   );

   pbs_fsm #(
      .DEB_MS(DEB_MS), .BLANK_MS(BLANK_MS), .INT_MIN_MS(INT_MIN_MS),
      .PD_MIN_MS(PD_MIN_MS), .XW(XW), .PW(PW), .HW(HW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick_1ms),
      .pb_n(pb_n), .kill_n(kill_n), .uv_n(uv_n), .extra_ms(extra_ms),
      .ph_cnt(ph_cnt), .hold_cnt(hold_cnt),
      .ph_clr(ph_clr), .hold_clr(hold_clr),
      .en_req(en_req), .int_req(int_req)
   );

   pbs_outstage #(.EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_out (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .int_req(int_req),
      .pwr_en(pwr_en), .int_n(int_n)
   );
endmodule

// File: rtl/pbpwr_seq_chk.sv
module pbpwr_seq_chk #(
   parameter bit EN_ACTIVE_HIGH = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic pb_n,
   input logic uv_n,
   input logic pwr_en,
   input logic int_n
);
   logic en_on;
   assign en_on = EN_ACTIVE_HIGH ? pwr_en : !pwr_en;

   // R1: outputs idle in the cycle after reset is seen
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!en_on && int_n));

   // R2: enable rises only after a press was present
   a_r2_on_after_press: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_on) |-> !$past(pb_n));

   // R8: enable never rises while undervoltage was flagged
   a_r8_uv_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_on) |-> $past(uv_n));

   // R6: interrupt returns high only with the button released or on power-off
   a_r6_int_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_n) |-> ($past(pb_n) || !en_on));

   // R11: interrupt low only while enabled
   a_r11_int_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      !int_n |-> en_on);
endmodule

bind pbpwr_seq pbpwr_seq_chk #(.EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)) chk_i (
   .clk(clk), .rst_n(rst_n), .pb_n(pb_n), .uv_n(uv_n),
   .pwr_en(pwr_en), .int_n(int_n)
);

// File: tb/pbpwr_seq_tb_top.sv
module pbpwr_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        pb_n = 1'b1;
   logic        kill_n = 1'b0;
   logic        uv_n = 1'b1;
   logic [15:0] extra = '0;
   logic        en_hi, int_hi, en_lo, int_lo;

   int unsigned cyc = 0;
   int unsigned t0 = 0;
   int          checks = 0;
   int          errors = 0;

   int unsigned q_cyc[$];
   bit          q_en[$];
   bit          q_int[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   pbpwr_seq #(.EN_ACTIVE_HIGH(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .pb_n(pb_n),
      .kill_n(kill_n), .uv_n(uv_n), .extra_ms(extra),
      .pwr_en(en_hi), .int_n(int_hi)
   );

   pbpwr_seq #(.EN_ACTIVE_HIGH(1'b0)) dut_lo_i (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .pb_n(pb_n),
      .kill_n(kill_n), .uv_n(uv_n), .extra_ms(extra),
      .pwr_en(en_lo), .int_n(int_lo)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items when their cycle is reached
   always @(negedge clk) begin
      while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
         checks++;
         if (q_cyc[0] != cyc) begin
            errors++;
            $display("FAIL %s: sample missed, at cycle %0d expected %0d",
                     q_tag[0], cyc, q_cyc[0]);
         end else if (en_hi !== q_en[0] || int_hi !== q_int[0]) begin
            errors++;
            $display("FAIL %s: cycle %0d en=%b int_n=%b expected en=%b int_n=%b",
                     q_tag[0], cyc, en_hi, int_hi, q_en[0], q_int[0]);
         end else if (en_lo !== !q_en[0] || int_lo !== q_int[0]) begin
            errors++;
            $display("FAIL R10 (%s): cycle %0d active-low en=%b int_n=%b expected en=%b int_n=%b",
                     q_tag[0], cyc, en_lo, int_lo, !q_en[0], q_int[0]);
         end
         void'(q_cyc.pop_front());
         void'(q_en.pop_front());
         void'(q_int.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic mark();
      t0 = cyc;
   endtask

   task automatic expect_at(input int unsigned k, input bit e, input bit i,
                            input string tag);
      q_cyc.push_back(t0 + k);
      q_en.push_back(e);
      q_int.push_back(i);
      q_tag.push_back(tag);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (q_cyc.size() != 0) @(negedge clk);
      wait_n(3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_n(3);
      mark(); expect_at(0, 0, 1, "R1");
      rst_n = 1'b1;
      expect_at(1, 0, 1, "R1");
      expect_at(2, 0, 1, "R1");
      drain();

      // R2: a press shorter than the debounce is rejected
      mark(); pb_n = 0;
      expect_at(19, 0, 1, "R2");
      wait_n(20); pb_n = 1;
      expect_at(40, 0, 1, "R2");
      drain();

      // R2 turn-on, R3 kill still low at the end of blanking
      mark(); pb_n = 0;
      expect_at(33, 0, 1, "R2");
      expect_at(34, 1, 1, "R2");
      expect_at(545, 1, 1, "R3");
      expect_at(546, 0, 1, "R3");
      wait_n(40); pb_n = 1;
      drain();

      // R3: kill pulse inside the window is ignored, kill confirmed
      mark(); pb_n = 0;
      expect_at(34, 1, 1, "R2");
      wait_n(40); pb_n = 1;
      wait_n(60); kill_n = 1;
      wait_n(100); kill_n = 0;
      expect_at(205, 1, 1, "R3");
      wait_n(6); kill_n = 1;
      expect_at(546, 1, 1, "R3");
      expect_at(600, 1, 1, "R3");
      drain();

      // R5: a short hold while on does nothing
      mark(); pb_n = 0;
      expect_at(20, 1, 1, "R5");
      wait_n(20); pb_n = 1;
      expect_at(30, 1, 1, "R5");
      drain();

      // R5/R6: 40-tick press raises a 32-tick interrupt
      mark(); pb_n = 0;
      expect_at(32, 1, 1, "R5");
      expect_at(33, 1, 0, "R5");
      wait_n(40); pb_n = 1;
      expect_at(64, 1, 0, "R6");
      expect_at(65, 1, 1, "R6");
      drain();

      // R5/R6/R7: sustained undervoltage with extra delay 20
      extra = 16'd20;
      mark(); uv_n = 0;
      expect_at(32, 1, 1, "R5");
      expect_at(33, 1, 0, "R5");
      expect_at(64, 1, 0, "R6");
      expect_at(65, 1, 1, "R6");
      expect_at(84, 1, 1, "R7");
      expect_at(85, 0, 1, "R7");
      drain();

      // R8: press while undervoltage is flagged
      mark(); pb_n = 0;
      expect_at(40, 0, 1, "R8");
      expect_at(60, 0, 1, "R8");
      wait_n(60); pb_n = 1; uv_n = 1; extra = '0;
      drain();

      // turn on again with kill confirmed
      mark(); pb_n = 0;
      expect_at(34, 1, 1, "R2");
      wait_n(40); pb_n = 1;
      expect_at(600, 1, 1, "R3");
      drain();

      // R7: long press with zero extra delay, then R9 rearm
      mark(); pb_n = 0;
      expect_at(32, 1, 1, "R7");
      expect_at(33, 1, 0, "R5");
      expect_at(64, 1, 0, "R7");
      expect_at(65, 0, 1, "R7");
      expect_at(150, 0, 1, "R9");
      wait_n(150); pb_n = 1;
      wait_n(5);
      mark(); pb_n = 0;
      expect_at(34, 1, 1, "R9");
      wait_n(40); pb_n = 1;
      expect_at(600, 1, 1, "R3");
      drain();

      // R4: kill while running
      mark(); kill_n = 0;
      expect_at(1, 1, 1, "R4");
      expect_at(2, 0, 1, "R4");
      expect_at(10, 0, 1, "R11");
      drain();
      kill_n = 1;

      // R4: kill while the interrupt is low
      mark(); pb_n = 0;
      expect_at(34, 1, 1, "R2");
      wait_n(40); pb_n = 1;
      wait_n(560);
      mark(); pb_n = 0;
      expect_at(33, 1, 0, "R5");
      wait_n(36); kill_n = 0;
      expect_at(37, 1, 0, "R4");
      expect_at(38, 0, 1, "R4");
      wait_n(4); pb_n = 1; kill_n = 1;
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule